// File: doc/BRIEF.md
# Switch-Selected Wavetable Tone Generator

This block produces a stepped sinusoid for a small resistor-ladder DAC. A reloadable down-counter, clocked by the system clock, sets the time between samples. Each time it expires, the next entry of a fixed waveform table is registered onto the sample output, and the table index advances. Pitch is set only by the sample period; the table never changes length while a note plays.

Three switch inputs choose one of three notes, and each note has its own sample period given as a parameter. The defaults of 2987, 3551 and 4735 cycles give about 523, 440 and 330 Hz at a 50 MHz clock. With no switch pressed the generator is stopped and the output rests at midscale.

A mode input swaps the 32-entry 4-bit sine for a 64-entry 6-bit instrument table. A one-cycle strobe marks every new sample.

Top module: `tone_gen`

## Requirements
- R1: After reset `sample_o` is 8, `strobe_o` is low and the block is stopped.
- R2: The lowest-numbered asserted bit of `sw_i` selects the note (bit 0 selects note 0, bit 1 selects note 1, bit 2 selects note 2). When no bit is set, the block is stopped.
- R3: While a note plays, `strobe_o` pulses for one cycle every P cycles, where P is that note's period parameter. The first pulse comes P cycles after the clock edge that registers the new selection.
- R4: In sine mode (`inst_i`=0) the samples are taken from index 0 upward of the table 8,9,11,12,13,14,14,15,15,15,14,14,13,12,11,9,8,7,5,4,3,2,2,1,1,1,2,2,3,4,5,7. The value sits in `sample_o[3:0]`, and `sample_o[5:4]` is 0.
- R5: Each strobe advances the index by one. In sine mode the index wraps from 31 to 0.
- R6: In the stopped state no strobe occurs and `sample_o` holds midscale: 8 in sine mode, 32 in instrument mode. The index returns to 0, so the next note starts at entry 0.
- R7: Moving from one note to another reloads the counter at once, so the next sample comes after the new period. The index carries on from where it was.
- R8: In instrument mode (`inst_i`=1), entry k of the 64-entry 6-bit table is 32+2k for k<16, 94-2k for 16<=k<48, and 2k-94 for k>=48. The index wraps from 63 to 0.
- R9: A change of `inst_i` while a note plays resets the index to 0 and reloads the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sw_i | input | 3 | Note switches, bit 0 has the highest priority |
| inst_i | input | 1 | 0: 32-entry sine table, 1: 64-entry instrument table |
| sample_o | output | 6 | Registered DAC code |
| strobe_o | output | 1 | High for one cycle when sample_o takes a new table value |

## Verification
The bench plays one note long enough for the sine index to wrap. It then steps to a slower note and to a faster one without stopping; because each period is different, a missed reload shows up as a wrong gap, and a reset index shows up as a wrong value. Patterns with several switches set, matched against a single switch, separate priority errors from period errors. Stop and restart, a mode change in the middle of a note, and a full pass through the 64-entry table check the midscale rest, the index restart and the longer wrap.

// File: rtl/tone_pkg.sv
package tone_pkg;
  localparam int WAVE_W   = 6;
  localparam int IDX_W    = 6;
  localparam int SINE_LEN = 32;
  localparam int INST_LEN = 64;

  typedef enum logic [1:0] {
    NOTE_STOP = 2'd0,
    NOTE_0    = 2'd1,
    NOTE_1    = 2'd2,
    NOTE_2    = 2'd3
  } note_e;

  function automatic logic [3:0] sine_val(input logic [4:0] k);
    logic [3:0] v;
    case (k)
      5'd0:  v = 4'd8;   5'd1:  v = 4'd9;   5'd2:  v = 4'd11;  5'd3:  v = 4'd12;
      5'd4:  v = 4'd13;  5'd5:  v = 4'd14;  5'd6:  v = 4'd14;  5'd7:  v = 4'd15;
      5'd8:  v = 4'd15;  5'd9:  v = 4'd15;  5'd10: v = 4'd14;  5'd11: v = 4'd14;
      5'd12: v = 4'd13;  5'd13: v = 4'd12;  5'd14: v = 4'd11;  5'd15: v = 4'd9;
      5'd16: v = 4'd8;   5'd17: v = 4'd7;   5'd18: v = 4'd5;   5'd19: v = 4'd4;
      5'd20: v = 4'd3;   5'd21: v = 4'd2;   5'd22: v = 4'd2;   5'd23: v = 4'd1;
      5'd24: v = 4'd1;   5'd25: v = 4'd1;   5'd26: v = 4'd2;   5'd27: v = 4'd2;
      5'd28: v = 4'd3;   5'd29: v = 4'd4;   5'd30: v = 4'd5;   default: v = 4'd7;
    endcase
    return v;
  endfunction

  function automatic logic [WAVE_W-1:0] inst_val(input logic [IDX_W-1:0] k);
    int kk;
    int v;
    kk = int'(k);
    if (kk < 16)      v = 32 + 2 * kk;
    else if (kk < 48) v = 94 - 2 * kk;
    else              v = 2 * kk - 94;
    return WAVE_W'(v);
  endfunction

  function automatic logic [IDX_W-1:0] idx_step(input logic [IDX_W-1:0] k, input logic inst);
    logic [IDX_W-1:0] last;
    last = inst ? IDX_W'(INST_LEN - 1) : IDX_W'(SINE_LEN - 1);
    return (k >= last) ? '0 : k + IDX_W'(1);
  endfunction

  function automatic logic [WAVE_W-1:0] mid_val(input logic inst);
    return inst ? WAVE_W'(32) : WAVE_W'(8);
  endfunction
endpackage

// File: rtl/tone_note_sel.sv
module tone_note_sel
  import tone_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int PERIOD0 = 2987,
  parameter int PERIOD1 = 3551,
  parameter int PERIOD2 = 4735
) (
  input  logic [2:0]       sw_i,
  output note_e            note_o,
  output logic [CNT_W-1:0] period_o
);
  // lowest-numbered switch wins
  always_comb begin
    if (sw_i[0]) begin
      note_o   = NOTE_0;
      period_o = CNT_W'(PERIOD0);
    end else if (sw_i[1]) begin
      note_o   = NOTE_1;
      period_o = CNT_W'(PERIOD1);
    end else if (sw_i[2]) begin
      note_o   = NOTE_2;
      period_o = CNT_W'(PERIOD2);
    end else begin
      note_o   = NOTE_STOP;
      period_o = CNT_W'(PERIOD0);
    end
  end
endmodule

// File: rtl/tone_tick_timer.sv
module tone_tick_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] period_i,
  output logic             tick_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] reload;

  assign reload = period_i - CNT_W'(1);
  assign tick_o = run_i && !load_i && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (!run_i)                cnt_q <= '0;
    else if (load_i || cnt_q == '0) cnt_q <= reload;
    else                            cnt_q <= cnt_q - CNT_W'(1);
  end

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !load_i) |-> (cnt_q < period_i)); // R3
  AST_TICK_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> (cnt_q == $past(period_i) - CNT_W'(1))); // R3
endmodule

// File: rtl/tone_wave_rom.sv
module tone_wave_rom
  import tone_pkg::*;
(
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              inst_i,
  output logic [WAVE_W-1:0] val_o
);
  logic [WAVE_W-1:0] sine_ext;

  assign sine_ext = {2'b00, sine_val(idx_i[4:0])};
  assign val_o    = inst_i ? inst_val(idx_i) : sine_ext;
endmodule

// File: rtl/tone_gen.sv
module tone_gen
  import tone_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int PERIOD0 = 2987,
  parameter int PERIOD1 = 3551,
  parameter int PERIOD2 = 4735
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        sw_i,
  input  logic              inst_i,
  output logic [WAVE_W-1:0] sample_o,
  output logic              strobe_o
);
  note_e             note_d, note_q;
  logic [CNT_W-1:0]  period;
  logic              inst_q;
  logic [IDX_W-1:0]  idx_q;
  logic [WAVE_W-1:0] sample_q;
  logic [WAVE_W-1:0] rom_val;
  logic              strobe_q;
  logic              run, load, tick;

  tone_note_sel #(
    .CNT_W(CNT_W), .PERIOD0(PERIOD0), .PERIOD1(PERIOD1), .PERIOD2(PERIOD2)
  ) u_sel (
    .sw_i(sw_i), .note_o(note_d), .period_o(period)
  );

  assign run  = (note_d != NOTE_STOP);
  assign load = (note_d != note_q) || (inst_i != inst_q);

  tone_tick_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run), .load_i(load),
    .period_i(period), .tick_o(tick)
  );

  tone_wave_rom u_rom (.idx_i(idx_q), .inst_i(inst_q), .val_o(rom_val));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      note_q   <= NOTE_STOP;
      inst_q   <= 1'b0;
      idx_q    <= '0;
      sample_q <= mid_val(1'b0);
      strobe_q <= 1'b0;
    end else begin
      note_q   <= note_d;
      inst_q   <= inst_i;
      strobe_q <= 1'b0;
      if (!run) begin
        idx_q    <= '0;
        sample_q <= mid_val(inst_i);
      end else if (inst_i != inst_q) begin
        idx_q <= '0;
      end else if (tick) begin
        sample_q <= rom_val;
        idx_q    <= idx_step(idx_q, inst_q);
        strobe_q <= 1'b1;
      end
    end
  end

  assign sample_o = sample_q;
  assign strobe_o = strobe_q;

  AST_STOP_MID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (note_q == NOTE_STOP) |-> (sample_o == mid_val(inst_q) && !strobe_o)); // R6
  AST_PRIO_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_i[0] |=> (note_q == NOTE_0)); // R2
  AST_SINE_IDX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inst_q |-> (idx_q < IDX_W'(SINE_LEN))); // R5
  AST_IDX_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_o |-> (idx_q == idx_step($past(idx_q), inst_q))); // R5
  AST_STROBE_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_o |-> (note_q != NOTE_STOP)); // R3
  AST_SINE_HI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_o && !inst_q) |-> (sample_o[5:4] == 2'b00)); // R4
endmodule

// File: tb/sim_tone_gen.sv
module sim_tone_gen;
  localparam int P0 = 5;
  localparam int P1 = 7;
  localparam int P2 = 11;

  typedef struct packed {
    logic [5:0] val;
    int         per;
  } item_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] sw = 3'b000;
  logic       inst = 1'b0;
  logic [5:0] sample;
  logic       strobe;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int ref_cyc = 0;
  int exp_idx = 0;
  item_t q[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  tone_gen #(.CNT_W(8), .PERIOD0(P0), .PERIOD1(P1), .PERIOD2(P2)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .sw_i(sw), .inst_i(inst),
    .sample_o(sample), .strobe_o(strobe)
  );

  function automatic logic [5:0] exp_sine(input int k);
    int t[32] = '{8,9,11,12,13,14,14,15,15,15,14,14,13,12,11,9,
                  8,7,5,4,3,2,2,1,1,1,2,2,3,4,5,7};
    return 6'(t[k]);
  endfunction

  function automatic logic [5:0] exp_inst(input int k);
    if (k < 16) return 6'(32 + 2 * k);
    if (k < 48) return 6'(94 - 2 * k);
    return 6'(2 * k - 94);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // driver: apply selection, push expected samples, wait until consumed
  task automatic play(input logic [2:0] s, input logic m, input int per, input int n);
    @(negedge clk);
    #1;
    if (m != inst) exp_idx = 0;            // R9 index restart
    for (int i = 0; i < n; i++) begin
      item_t it;
      it.val = m ? exp_inst(exp_idx) : exp_sine(exp_idx);
      it.per = per;
      q.push_back(it);
      exp_idx = (exp_idx + 1) % (m ? 64 : 32);
    end
    sw = s;
    inst = m;
    ref_cyc = cyc + 1;
    while (q.size() != 0) @(negedge clk);
  endtask

  task automatic stop_and_check(input string req, input int mid);
    @(negedge clk);
    #1;
    sw = 3'b000;
    exp_idx = 0;
    repeat (2) @(negedge clk);
    check(req, int'(sample), mid);
    repeat (25) @(negedge clk);            // monitor flags any strobe here
    check(req, int'(sample), mid);
  endtask

  // monitor: pop and compare value and spacing of each strobe
  always @(negedge clk) begin
    if (rst_n && strobe) begin
      if (q.size() == 0) begin
        total++;
        bad++;
        $display("FAIL R6: actual=strobe expected=no strobe at cycle %0d", cyc);
      end else begin
        item_t it;
        it = q.pop_front();
        check("R4/R8 value", int'(sample), int'(it.val));
        check("R3/R7 period", cyc - ref_cyc, it.per);
      end
      ref_cyc = cyc;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 sample", int'(sample), 8);
    check("R1 strobe", int'(strobe), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 idle", int'(sample), 8);
    play(3'b001, 1'b0, P0, 40);            // R4, R5 wrap past 31
    play(3'b100, 1'b0, P2, 10);            // R7 continue index
    play(3'b110, 1'b0, P1, 6);             // R2 priority -> note 1
    play(3'b111, 1'b0, P0, 4);             // R2 priority -> note 0
    stop_and_check("R6 stop sine", 8);
    play(3'b010, 1'b0, P1, 5);             // R6 restart at entry 0
    play(3'b010, 1'b1, P1, 70);            // R8, R9 mode switch, wrap 63
    play(3'b101, 1'b1, P0, 8);             // R2, R7 in instrument mode
    stop_and_check("R8 stop inst", 32);
    play(3'b100, 1'b1, P2, 3);             // R6 restart at entry 0
    repeat (3) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule